// File: doc/BRIEF.md
# System-Coprocessor Hazard Sequence Checker

The checker observes decoded instructions as they issue in order, one per cycle, each marked by a valid strobe. For each instruction it reports whether the instruction completes a sequence that breaks a system-coprocessor spacing rule. Each instruction carries a class, a coprocessor register number, the data being written, and a cache-line index. The rules covered are:

- a move-from that directly follows a move-to;
- a CACHE operation that comes too soon after a store to the same line;
- the delayed cacheability switch after a configuration write;
- a combined privilege-mode write;
- a branch issued right after the interrupt-timing bit is set;
- register dependencies around the TLB operations.

The checker only reports. It never stalls, reorders or models the TLB or the caches.

Each accepted instruction produces a registered result one cycle later:

- an error pulse or a warning pulse;
- a 3-bit reason code;
- the cacheability that the fetch of that instruction still used;
- a sticky status vector that collects every reason raised since reset.

Three blocks sit under the top:
- a six-deep history of earlier instructions;
- a scanner for the store-to-CACHE spacing rule;
- a small state machine for the cacheability window, with states STEADY, GAP1 and GAP2.

The state machine has these transitions:
- STEADY goes to GAP1 when a configuration write changes the cacheability field.
- GAP1 goes to GAP2, and GAP2 goes to STEADY, on each later valid instruction.
- A further change while in GAP1 or GAP2 goes back to GAP1.

Top module: `cp0_hazard_chk`

## Requirements
- R1: Instruction classes are encoded on `in_cls` as follows: 0 other, 1 MTC0, 2 MFC0, 3 load, 4 store, 5 CACHE, 6 branch/jump, 7 TLBP, 8 TLBR, 9 TLBWI, 10 TLBWR, 11 ERET. An MFC0 whose preceding valid instruction is an MTC0 raises an error with code 1.
- R2: A CACHE (class 5) is compared against each store (class 4) in the last six valid instructions that has the same `in_line`. If fewer than two instructions that are neither load nor CACHE lie between that store and the CACHE, the checker raises an error with code 2. A different line never matches.
- R3: The configuration register is number 16 and its cacheability field is bits [2:0]. Value 2 means uncached, and the reset value is 3. An MTC0 that changes this field takes effect for fetch only from the third valid instruction after it. The MTC0 itself and the next two valid instructions report the old value on `fetch_uc_o`, which is 1 when the effective field equals 2. Those next two instructions also raise a warning with code 3.
- R4: The status register is number 12. Its mode field is bits [4:3] and resets to 0 (kernel), EXL is bit 1 and ERL is bit 2. An MTC0 to register 12 that changes the mode field while setting both EXL and ERL raises an error with code 4. Setting EXL with the mode field unchanged, and changing the mode field later with ERL clear, raises nothing.
- R5: Bit 24 of a status-register MTC0 is the interrupt-timing bit. A branch (class 6) whose preceding valid instruction set that bit raises a warning with code 5 and no error.
- R6: The TLB register numbers are Index 0, EntryLo0 2, EntryLo1 3, PageMask 5 and EntryHi 10. Each of the following dependent pairs of adjacent valid instructions raises an error with code 6:
  - TLBP after an MTC0 to PageMask or EntryHi;
  - TLBR after an MTC0 to Index;
  - TLBWI after an MTC0 to Index, PageMask, EntryHi or either EntryLo;
  - TLBWR after an MTC0 to PageMask, EntryHi or either EntryLo;
  - an MFC0 of Index after TLBP;
  - an MFC0 of PageMask, EntryHi or either EntryLo after TLBR.
- R7: Results appear in the cycle after the instruction is accepted. Codes 1, 2, 4 and 6 drive `err_o`, and codes 3 and 5 drive `warn_o`. When several reasons are raised at once, `code_o` shows the smallest. Every raised code c sets `sticky_o[c-1]`, which stays set until reset.
- R8: A cycle with `in_valid` low does not advance the history and does not count toward any distance. In the cycle after such a cycle, `err_o` and `warn_o` are low.
- R9: A synchronous active-high `rst` clears the history, the sticky vector and all outputs, and restores the register shadows to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_cls | input | 4 | Instruction class |
| in_reg | input | 5 | Coprocessor register number |
| in_wdata | input | 32 | Data written by a move-to |
| in_line | input | 8 | Cache-line index for stores and CACHE operations |
| err_o | output | 1 | Error pulse |
| warn_o | output | 1 | Warning pulse |
| code_o | output | 3 | Reason code of the reported event |
| fetch_uc_o | output | 1 | Fetch of the last instruction used uncached mode |
| sticky_o | output | 6 | Accumulated reasons, bit c-1 for code c |

## Verification
The spacing scanner and the cacheability window can fire on the same instruction. The bench provokes this with a store, then a configuration write that switches to uncached, then a CACHE to the same line. That CACHE is too close to the store and also sits in the first gap slot of the window. The bench expects both pulses, code 2 as the smaller code, both sticky bits, and the old cacheability on the fetch flag. A second coincidence is a window that spans idle cycles: the window must still cover the next two valid instructions rather than expire on the idle ones.

// File: rtl/cp0h_pkg.sv
package cp0h_pkg;
    typedef enum logic [3:0] {
        CL_OTHER  = 4'd0,
        CL_MTC0   = 4'd1,
        CL_MFC0   = 4'd2,
        CL_LOAD   = 4'd3,
        CL_STORE  = 4'd4,
        CL_CACHE  = 4'd5,
        CL_BRANCH = 4'd6,
        CL_TLBP   = 4'd7,
        CL_TLBR   = 4'd8,
        CL_TLBWI  = 4'd9,
        CL_TLBWR  = 4'd10,
        CL_ERET   = 4'd11
    } icls_e;

    typedef enum logic [2:0] {
        RC_NONE    = 3'd0,
        RC_MOVE    = 3'd1,
        RC_SPACING = 3'd2,
        RC_K0WIN   = 3'd3,
        RC_MODEWIN = 3'd4,
        RC_ITS     = 3'd5,
        RC_TLB     = 3'd6
    } rcode_e;

    localparam int unsigned NUM_RC = 6;

    localparam logic [4:0] REG_INDEX  = 5'd0;
    localparam logic [4:0] REG_ELO0   = 5'd2;
    localparam logic [4:0] REG_ELO1   = 5'd3;
    localparam logic [4:0] REG_PMASK  = 5'd5;
    localparam logic [4:0] REG_EHI    = 5'd10;
    localparam logic [4:0] REG_STATUS = 5'd12;
    localparam logic [4:0] REG_CONFIG = 5'd16;

    localparam int unsigned STS_EXL = 1;
    localparam int unsigned STS_ERL = 2;
    localparam int unsigned STS_KSU = 3;
    localparam int unsigned STS_ITS = 24;

    localparam logic [2:0] K0_UNCACHED = 3'd2;
    localparam logic [2:0] K0_RESET    = 3'd3;

    typedef struct packed {
        logic       vld;
        icls_e      cls;
        logic [4:0] rnum;
        logic       its;
    } hent_t;
endpackage

// File: rtl/cp0h_history.sv
module cp0h_history
    import cp0h_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int LINE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  hent_t                         new_ent,
    input  logic [LINE_W-1:0]             new_line,
    output hent_t [DEPTH-1:0]             ent_o,
    output logic  [DEPTH-1:0][LINE_W-1:0] line_o
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_o[0]  <= '0;
                    line_o[0] <= '0;
                end else if (push) begin
                    ent_o[0]  <= new_ent;
                    line_o[0] <= new_line;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_o[s]  <= '0;
                    line_o[s] <= '0;
                end else if (push) begin
                    ent_o[s]  <= ent_o[s-1];
                    line_o[s] <= line_o[s-1];
                end
            end
        end
    end

    p_shift_r8: assert property (@(posedge clk) disable iff (rst)
        push |=> (ent_o[1] == $past(ent_o[0])));
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !push |=> $stable(ent_o));
endmodule

// File: rtl/cp0h_spacing.sv
module cp0h_spacing
    import cp0h_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int LINE_W = 8,
    parameter int MIN_GAP = 2
) (
    input  hent_t [DEPTH-1:0]             ent,
    input  logic  [DEPTH-1:0][LINE_W-1:0] line,
    input  logic                          cur_cache,
    input  logic  [LINE_W-1:0]            cur_line,
    output logic                          hit
);
    always_comb begin
        int good;
        good = 0;
        hit  = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ent[k].vld && ent[k].cls == CL_STORE && line[k] == cur_line
                && good < MIN_GAP)
                hit = 1'b1;
            if (ent[k].vld && ent[k].cls != CL_LOAD && ent[k].cls != CL_CACHE)
                good = good + 1;
        end
        hit = hit & cur_cache;
    end
endmodule

// File: rtl/cp0h_k0win.sv
module cp0h_k0win
    import cp0h_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       cfg_wr,
    input  logic [2:0] wr_k0,
    output logic [2:0] eff_k0,
    output logic       in_window
);
    typedef enum logic [1:0] {KS_STEADY, KS_GAP1, KS_GAP2} kstate_e;

    kstate_e    state, state_nx;
    logic [2:0] arch_k0, held_k0;
    logic       chg;

    assign chg       = adv && cfg_wr && (wr_k0 != arch_k0);
    assign eff_k0    = (state == KS_STEADY) ? arch_k0 : held_k0;
    assign in_window = (state != KS_STEADY);

    always_comb begin
        state_nx = state;
        unique case (state)
            KS_STEADY: if (chg) state_nx = KS_GAP1;
            KS_GAP1:   if (adv) state_nx = chg ? KS_GAP1 : KS_GAP2;
            KS_GAP2:   if (adv) state_nx = chg ? KS_GAP1 : KS_STEADY;
            default:   state_nx = KS_STEADY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= KS_STEADY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arch_k0 <= K0_RESET;
            held_k0 <= K0_RESET;
        end else begin
            if (chg)               held_k0 <= eff_k0;
            if (adv && cfg_wr)     arch_k0 <= wr_k0;
        end
    end

    p_gap2_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (state == KS_GAP2 && adv) |=> (state != KS_GAP2));
    p_gap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> $stable(state));
endmodule

// File: rtl/cp0_hazard_chk.sv
module cp0_hazard_chk
    import cp0h_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int LINE_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_cls,
    input  logic [4:0]        in_reg,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LINE_W-1:0] in_line,
    output logic              err_o,
    output logic              warn_o,
    output logic [2:0]        code_o,
    output logic              fetch_uc_o,
    output logic [NUM_RC-1:0] sticky_o
);
    icls_e cls;
    assign cls = icls_e'(in_cls);

    hent_t                         new_ent;
    hent_t [DEPTH-1:0]             hist;
    logic  [DEPTH-1:0][LINE_W-1:0] hline;
    hent_t                         h0;
    logic                          is_mtc0_sts, is_mtc0_cfg;
    logic  [1:0]                   ksu_q, ksu_new;
    logic                          r_move, r_space, r_k0, r_mode, r_its, r_tlb;
    logic  [NUM_RC-1:0]            raised;
    logic  [2:0]                   eff_k0;
    logic                          win;
    rcode_e                        code_nx;

    assign h0          = hist[0];
    assign is_mtc0_sts = (cls == CL_MTC0) && (in_reg == REG_STATUS);
    assign is_mtc0_cfg = (cls == CL_MTC0) && (in_reg == REG_CONFIG);
    assign ksu_new     = in_wdata[STS_KSU +: 2];

    always_comb begin
        new_ent      = '0;
        new_ent.vld  = 1'b1;
        new_ent.cls  = cls;
        new_ent.rnum = in_reg;
        new_ent.its  = is_mtc0_sts && in_wdata[STS_ITS];
    end

    cp0h_history #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_hist (
        .clk(clk), .rst(rst), .push(in_valid), .new_ent(new_ent),
        .new_line(in_line), .ent_o(hist), .line_o(hline));

    cp0h_spacing #(.DEPTH(DEPTH), .LINE_W(LINE_W), .MIN_GAP(2)) u_space (
        .ent(hist), .line(hline), .cur_cache(cls == CL_CACHE),
        .cur_line(in_line), .hit(r_space));

    cp0h_k0win u_k0 (
        .clk(clk), .rst(rst), .adv(in_valid), .cfg_wr(is_mtc0_cfg),
        .wr_k0(in_wdata[2:0]), .eff_k0(eff_k0), .in_window(win));

    // Rule evaluation for the instruction presented this cycle
    assign r_move = (cls == CL_MFC0) && h0.vld && (h0.cls == CL_MTC0);
    assign r_k0   = win;
    assign r_mode = is_mtc0_sts && (ksu_new != ksu_q)
                    && in_wdata[STS_EXL] && in_wdata[STS_ERL];
    assign r_its  = (cls == CL_BRANCH) && h0.vld && h0.its;

    always_comb begin
        logic prev_mtc0, tlb_entry_reg;
        prev_mtc0     = h0.vld && (h0.cls == CL_MTC0);
        tlb_entry_reg = (in_reg == REG_PMASK) || (in_reg == REG_EHI)
                        || (in_reg == REG_ELO0) || (in_reg == REG_ELO1);
        r_tlb = 1'b0;
        unique case (cls)
            CL_TLBP:  r_tlb = prev_mtc0 && ((h0.rnum == REG_PMASK) || (h0.rnum == REG_EHI));
            CL_TLBR:  r_tlb = prev_mtc0 && (h0.rnum == REG_INDEX);
            CL_TLBWI: r_tlb = prev_mtc0 && ((h0.rnum == REG_PMASK) || (h0.rnum == REG_EHI)
                              || (h0.rnum == REG_ELO0) || (h0.rnum == REG_ELO1)
                              || (h0.rnum == REG_INDEX));
            CL_TLBWR: r_tlb = prev_mtc0 && ((h0.rnum == REG_PMASK) || (h0.rnum == REG_EHI)
                              || (h0.rnum == REG_ELO0) || (h0.rnum == REG_ELO1));
            CL_MFC0:  r_tlb = h0.vld && (((h0.cls == CL_TLBP) && (in_reg == REG_INDEX))
                              || ((h0.cls == CL_TLBR) && tlb_entry_reg));
            default:  r_tlb = 1'b0;
        endcase
    end

    assign raised = {r_tlb, r_its, r_mode, r_k0, r_space, r_move} & {NUM_RC{in_valid}};

    always_comb begin
        code_nx = RC_NONE;
        if (raised[5]) code_nx = RC_TLB;
        if (raised[4]) code_nx = RC_ITS;
        if (raised[3]) code_nx = RC_MODEWIN;
        if (raised[2]) code_nx = RC_K0WIN;
        if (raised[1]) code_nx = RC_SPACING;
        if (raised[0]) code_nx = RC_MOVE;
    end

    // Status shadow
    always_ff @(posedge clk) begin
        if (rst)                         ksu_q <= 2'b00;
        else if (in_valid && is_mtc0_sts) ksu_q <= ksu_new;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            err_o      <= 1'b0;
            warn_o     <= 1'b0;
            code_o     <= '0;
            fetch_uc_o <= 1'b0;
            sticky_o   <= '0;
        end else begin
            err_o    <= raised[0] | raised[1] | raised[3] | raised[5];
            warn_o   <= raised[2] | raised[4];
            code_o   <= code_nx;
            sticky_o <= sticky_o | raised;
            if (in_valid) fetch_uc_o <= (eff_k0 == K0_UNCACHED);
        end
    end

    p_flag_code_r7: assert property (@(posedge clk) disable iff (rst)
        (err_o || warn_o) |-> (code_o != RC_NONE));
    p_sticky_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (sticky_o != '0) |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!err_o && !warn_o));
    p_move_err_r1: assert property (@(posedge clk) disable iff (rst)
        (code_o == RC_MOVE) |-> err_o);
    p_its_warn_r5: assert property (@(posedge clk) disable iff (rst)
        (code_o == RC_ITS) |-> (warn_o && !err_o));
endmodule

// File: tb/test_cp0_hazard_chk.sv
`timescale 1ns/1ps
module test_cp0_hazard_chk;
    localparam logic [3:0] C_OTH = 4'd0, C_MTC0 = 4'd1, C_MFC0 = 4'd2, C_LOAD = 4'd3,
                           C_STORE = 4'd4, C_CACHE = 4'd5, C_BR = 4'd6, C_TLBP = 4'd7,
                           C_TLBR = 4'd8, C_TLBWI = 4'd9, C_TLBWR = 4'd10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_cls = '0;
    logic [4:0]  in_reg = '0;
    logic [31:0] in_wdata = '0;
    logic [7:0]  in_line = '0;
    logic        err_o, warn_o, fetch_uc_o;
    logic [2:0]  code_o;
    logic [5:0]  sticky_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cp0_hazard_chk i_cp0_hazard_chk (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_reg(in_reg),
        .in_wdata(in_wdata), .in_line(in_line), .err_o(err_o), .warn_o(warn_o),
        .code_o(code_o), .fetch_uc_o(fetch_uc_o), .sticky_o(sticky_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [4:0] r,
                         input logic [31:0] d, input logic [7:0] l);
        @(negedge clk);
        in_valid = 1'b1; in_cls = c; in_reg = r; in_wdata = d; in_line = l;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic flush();
        for (int i = 0; i < 6; i++) issue(C_OTH, 5'd0, 32'd0, 8'd0);
    endtask

    // expect err, warn, code in one call
    task automatic expect_ev(input string req, input logic e, input logic w, input logic [2:0] c);
        chk({req, " err"}, {31'd0, err_o}, {31'd0, e});
        chk({req, " warn"}, {31'd0, warn_o}, {31'd0, w});
        chk({req, " code"}, {29'd0, code_o}, {29'd0, c});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        // R9: reset state
        #1;
        chk("R9 err", {31'd0, err_o}, 32'd0);
        chk("R9 warn", {31'd0, warn_o}, 32'd0);
        chk("R9 code", {29'd0, code_o}, 32'd0);
        chk("R9 sticky", {26'd0, sticky_o}, 32'd0);
        chk("R9 fetch", {31'd0, fetch_uc_o}, 32'd0);

        // R1: MTC0 then MFC0
        issue(C_MTC0, 5'd9, 32'd1, 8'd0);
        issue(C_MFC0, 5'd9, 32'd0, 8'd0);
        expect_ev("R1 adjacent", 1'b1, 1'b0, 3'd1);
        issue(C_MTC0, 5'd9, 32'd1, 8'd0);
        bubble();
        chk("R8 idle quiet", {30'd0, err_o, warn_o}, 32'd0);
        issue(C_MFC0, 5'd9, 32'd0, 8'd0);
        expect_ev("R1 R8 bubble not counted", 1'b1, 1'b0, 3'd1);
        issue(C_MTC0, 5'd9, 32'd1, 8'd0);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        issue(C_MFC0, 5'd9, 32'd0, 8'd0);
        expect_ev("R1 separated", 1'b0, 1'b0, 3'd0);
        chk("R7 sticky move", {26'd0, sticky_o}, 32'h01);

        // R2: sweep filler count and filler kind
        for (int n = 0; n < 4; n++) begin
            for (int f = 0; f < 3; f++) begin
                logic [7:0] ln;
                int good;
                ln = 8'h10 + 8'(n * 3 + f);
                good = (f == 0) ? n : 0;
                flush();
                issue(C_STORE, 5'd0, 32'd0, ln);
                for (int i = 0; i < n; i++) begin
                    if (f == 0)      issue(C_OTH, 5'd0, 32'd0, 8'd0);
                    else if (f == 1) issue(C_LOAD, 5'd0, 32'd0, ln);
                    else             issue(C_CACHE, 5'd0, 32'd0, 8'hF0);
                end
                issue(C_CACHE, 5'd0, 32'd0, ln);
                expect_ev($sformatf("R2 n=%0d f=%0d", n, f), good < 2, 1'b0,
                          (good < 2) ? 3'd2 : 3'd0);
            end
        end
        flush();
        issue(C_STORE, 5'd0, 32'd0, 8'h55);
        issue(C_CACHE, 5'd0, 32'd0, 8'h56);
        expect_ev("R2 other line", 1'b0, 1'b0, 3'd0);
        flush();
        issue(C_STORE, 5'd0, 32'd0, 8'h57);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        issue(C_LOAD, 5'd0, 32'd0, 8'h57);
        issue(C_STORE, 5'd0, 32'd0, 8'h58);
        issue(C_CACHE, 5'd0, 32'd0, 8'h57);
        expect_ev("R2 mixed fillers", 1'b0, 1'b0, 3'd0);

        // R3: cacheability window with idle cycles inside
        do_reset();
        issue(C_MTC0, 5'd16, 32'd2, 8'd0);
        chk("R3 mtc0 fetch old", {31'd0, fetch_uc_o}, 32'd0);
        bubble(); bubble();
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        expect_ev("R3 gap1", 1'b0, 1'b1, 3'd3);
        chk("R3 gap1 fetch old", {31'd0, fetch_uc_o}, 32'd0);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        expect_ev("R3 gap2", 1'b0, 1'b1, 3'd3);
        chk("R3 gap2 fetch old", {31'd0, fetch_uc_o}, 32'd0);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        expect_ev("R3 third", 1'b0, 1'b0, 3'd0);
        chk("R3 third fetch new", {31'd0, fetch_uc_o}, 32'd1);
        issue(C_MTC0, 5'd16, 32'd3, 8'd0);
        chk("R3 back mtc0", {31'd0, fetch_uc_o}, 32'd1);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        chk("R3 back gap1", {31'd0, fetch_uc_o}, 32'd1);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        chk("R3 back gap2", {31'd0, fetch_uc_o}, 32'd1);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        chk("R3 back third", {31'd0, fetch_uc_o}, 32'd0);
        issue(C_MTC0, 5'd16, 32'd3, 8'd0);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        expect_ev("R3 unchanged field no window", 1'b0, 1'b0, 3'd0);

        // Coincidence R2 + R3, R7 priority and sticky
        do_reset();
        issue(C_STORE, 5'd0, 32'd0, 8'h33);
        issue(C_MTC0, 5'd16, 32'd2, 8'd0);
        issue(C_CACHE, 5'd0, 32'd0, 8'h33);
        expect_ev("R7 R2 R3 same cycle", 1'b1, 1'b1, 3'd2);
        chk("R7 sticky both", {26'd0, sticky_o}, 32'h06);
        chk("R3 coincident fetch old", {31'd0, fetch_uc_o}, 32'd0);

        // R4: combined mode write vs safe sequence
        do_reset();
        issue(C_MTC0, 5'd12, 32'h16, 8'd0); // mode 2, ERL, EXL
        expect_ev("R4 combined", 1'b1, 1'b0, 3'd4);
        do_reset();
        issue(C_MTC0, 5'd12, 32'h02, 8'd0); // EXL, mode kernel
        expect_ev("R4 safe step1", 1'b0, 1'b0, 3'd0);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        issue(C_MTC0, 5'd12, 32'h12, 8'd0); // mode 2, EXL, ERL clear
        expect_ev("R4 safe step2", 1'b0, 1'b0, 3'd0);
        chk("R4 safe sticky", {26'd0, sticky_o}, 32'd0);

        // R5: interrupt-timing bit then branch
        issue(C_MTC0, 5'd12, 32'h0100_0000, 8'd0);
        issue(C_BR, 5'd0, 32'd0, 8'd0);
        expect_ev("R5 branch after set", 1'b0, 1'b1, 3'd5);
        issue(C_MTC0, 5'd12, 32'h0100_0000, 8'd0);
        issue(C_OTH, 5'd0, 32'd0, 8'd0);
        issue(C_BR, 5'd0, 32'd0, 8'd0);
        expect_ev("R5 branch later", 1'b0, 1'b0, 3'd0);

        // R6: TLB dependencies
        issue(C_MTC0, 5'd10, 32'd0, 8'd0);
        issue(C_TLBP, 5'd0, 32'd0, 8'd0);
        expect_ev("R6 ehi then tlbp", 1'b1, 1'b0, 3'd6);
        issue(C_MFC0, 5'd0, 32'd0, 8'd0);
        expect_ev("R6 tlbp then index read", 1'b1, 1'b0, 3'd6);
        issue(C_MTC0, 5'd2, 32'd0, 8'd0);
        issue(C_TLBP, 5'd0, 32'd0, 8'd0);
        expect_ev("R6 elo0 then tlbp", 1'b0, 1'b0, 3'd0);
        issue(C_MTC0, 5'd0, 32'd0, 8'd0);
        issue(C_TLBR, 5'd0, 32'd0, 8'd0);
        expect_ev("R6 index then tlbr", 1'b1, 1'b0, 3'd6);
        issue(C_MFC0, 5'd5, 32'd0, 8'd0);
        expect_ev("R6 tlbr then pmask read", 1'b1, 1'b0, 3'd6);
        issue(C_MTC0, 5'd0, 32'd0, 8'd0);
        issue(C_TLBWR, 5'd0, 32'd0, 8'd0);
        expect_ev("R6 index then tlbwr", 1'b0, 1'b0, 3'd0);
        issue(C_MTC0, 5'd0, 32'd0, 8'd0);
        issue(C_TLBWI, 5'd0, 32'd0, 8'd0);
        expect_ev("R6 index then tlbwi", 1'b1, 1'b0, 3'd6);
        chk("R7 sticky accumulate", {26'd0, sticky_o}, 32'h30);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule